// File: doc/BRIEF.md
# Predicated single-to-bfloat16 narrowing converter

This block takes a vector of 32-bit single-precision lanes and narrows each active lane to bfloat16. The result goes into the upper 16-bit half of that lane's 32-bit slot in the destination. The lower halves of every slot, and the upper halves of inactive lanes, keep the old destination contents, which come in on a separate port. A byte-granular predicate selects the lanes. For each lane only the bit at the lane's lowest byte counts.

The conversion follows the single-precision control settings. Four rounding directions are applied to the sixteen dropped mantissa bits. Flush-to-zero acts on subnormal inputs. Default-NaN replaces every NaN result with one canonical value. Five IEEE exception conditions are produced, ORed across the active lanes only, so the caller can fold them into its sticky status register. Inputs are sampled on one clock edge, and the merged vector and the flags appear as registered outputs one cycle later.

Top module: `bf16_narrow_top`

## Requirements
- R1: For lane e, the bfloat16 result of an active lane appears on `dst_new[32e+31:32e+16]`. Every lower half `dst_new[32e+15:32e]` always equals `dst_old` of the same bits.
- R2: Lane e is active when `pred[4e]` is 1. An inactive lane's upper half equals `dst_old`. The other predicate bits have no effect on any output.
- R3: Rounding follows `rmode`: 0 nearest-even, 1 toward +inf, 2 toward -inf, 3 toward zero. It is applied to the 16 dropped mantissa bits. A nonzero discarded part raises inexact.
- R4: If rounding carries the exponent to all ones, the result is a signed infinity and both overflow and inexact are raised. Modes that do not round away from zero keep the largest finite magnitude 0x7F7F with the input's sign, and raise inexact only.
- R5: A signalling NaN input (exponent all ones, mantissa nonzero, mantissa bit 22 clear) raises invalid. A NaN result is quiet. It keeps the sign and mantissa bits 21:16 when `dnan` is 0, and is 0x7FC0 when `dnan` is 1. Quiet NaN inputs raise no flag.
- R6: With `ftz` set, a subnormal input gives a zero of the same sign and raises input-denormal only.
- R7: With `ftz` clear, a subnormal input is rounded like a normal one. If the result is inexact, underflow and inexact are both raised. A carry into the smallest normal value is allowed.
- R8: `exc` is the OR of the flags from active lanes only. Bit 0 is invalid, bit 1 overflow, bit 2 underflow, bit 3 inexact and bit 4 input-denormal.
- R9: Outputs update one clock after the inputs are sampled. An active-low asynchronous reset clears `dst_new` and `exc` to zero.
- R10: Infinities and zeros convert exactly, keep their sign, and raise no flag. With `ftz` set a zero raises no input-denormal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_vec | input | VL | Single-precision source lanes |
| dst_old | input | VL | Prior destination contents |
| pred | input | VL/8 | Byte-granular governing predicate |
| rmode | input | 2 | Rounding direction |
| ftz | input | 1 | Flush subnormal inputs to zero |
| dnan | input | 1 | Replace NaN results with the default NaN |
| dst_new | output | VL | Merged destination vector |
| exc | output | 5 | Exception flags of active lanes |

## Verification
The bench aims at the halfway cases of nearest-even rounding, where a design that rounds half up gives 0x3F81 instead of 0x3F80. It also targets the largest finite input under each direction, where a converter that always saturates or always overflows returns the wrong one of 0x7F80 and 0x7F7F. Signalling and quiet NaNs are driven with and without default-NaN, which exposes a lost payload, a missing quiet bit or a spurious invalid. Subnormal inputs are driven with and without flush, exposing missing underflow or input-denormal flags. Mixed predicates that set the non-lane predicate bits, with faulting values placed in inactive lanes, show any design that writes those lanes or leaks their flags.

// File: rtl/bf16_narrow_top.sv
module bf16_narrow_top #(
  parameter int VL = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VL-1:0] src_vec,
  input  logic [VL-1:0] dst_old,
  input  logic [VL/8-1:0] pred,
  input  logic [1:0]    rmode,
  input  logic          ftz,
  input  logic          dnan,
  output logic [VL-1:0] dst_new,
  output logic [4:0]    exc
);
  localparam int LANES = VL / 32;

  function automatic logic [20:0] cvt(input logic [31:0] x, input logic [1:0] rm,
                                      input logic fz, input logic dn);
    logic        s, g, st, lsb, inx, inc;
    logic [7:0]  ex;
    logic [22:0] m;
    logic [14:0] sum;
    logic [15:0] r;
    logic [4:0]  fl;
    s   = x[31];
    ex  = x[30:23];
    m   = x[22:0];
    g   = m[15];
    st  = |m[14:0];
    lsb = m[16];
    inx = g | st;
    fl  = '0;
    case (rm)
      2'd0:    inc = g & (st | lsb);
      2'd1:    inc = !s & inx;
      2'd2:    inc = s & inx;
      default: inc = 1'b0;
    endcase
    sum = {ex, m[22:16]} + {14'd0, inc};
    if (ex == 8'hFF) begin
      if (m != '0) begin
        r     = dn ? 16'h7FC0 : {s, 8'hFF, 1'b1, m[21:16]};
        fl[0] = !m[22];
      end else begin
        r = {s, 8'hFF, 7'd0};
      end
    end else if (ex == 8'd0 && m != '0 && fz) begin
      r     = {s, 15'd0};
      fl[4] = 1'b1;
    end else begin
      r     = {s, sum};
      fl[3] = inx;
      fl[1] = (sum[14:7] == 8'hFF);
      fl[2] = (ex == 8'd0) && inx;
    end
    return {fl, r};
  endfunction

  logic [20:0]   res [LANES];
  logic [VL-1:0] nxt;
  logic [4:0]    nxt_exc;
  logic          live_q;
  logic          unused_pred_bits;

  assign unused_pred_bits = ^pred;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    assign res[e] = cvt(src_vec[32*e +: 32], rmode, ftz, dnan);
  end

  always_comb begin
    nxt     = dst_old;
    nxt_exc = '0;
    for (int e = 0; e < LANES; e++) begin
      if (pred[4*e]) begin
        nxt[32*e+16 +: 16] = res[e][15:0];
        nxt_exc            = nxt_exc | res[e][20:16];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_new <= '0;
      exc     <= '0;
      live_q  <= 1'b0;
    end else begin
      dst_new <= nxt;
      exc     <= nxt_exc;
      live_q  <= 1'b1;
    end
  end

  for (genvar e = 0; e < LANES; e++) begin : g_chk
    p_even_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> dst_new[32*e +: 16] == $past(dst_old[32*e +: 16]));
    p_inactive_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && !$past(pred[4*e])) |-> dst_new[32*e+16 +: 16] == $past(dst_old[32*e+16 +: 16]));
    p_default_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(pred[4*e]) && $past(dnan) &&
       dst_new[32*e+23 +: 8] == 8'hFF && dst_new[32*e+16 +: 7] != 7'd0)
      |-> dst_new[32*e+16 +: 16] == 16'h7FC0);
  end

  p_ovf_inexact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc[1] |-> exc[3]);
  p_ftz_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(ftz)) |-> !exc[2]);
  p_idle_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(pred) == '0) |-> exc == 5'd0);
endmodule

// File: tb/bf16_narrow_top_tb.sv
module bf16_narrow_top_tb;
  localparam int VL = 128;
  localparam int N  = 26;
  // fields: src(32) rmode(2) ftz dnan exp_bf16(16) exp_flags(5) req(4)
  localparam logic [60:0] VEC [N] = '{
    {32'h3F800000, 2'd0, 1'b0, 1'b0, 16'h3F80, 5'h00, 4'd3},  // R3 exact
    {32'h3F808000, 2'd0, 1'b0, 1'b0, 16'h3F80, 5'h08, 4'd3},  // R3 tie to even down
    {32'h3F818000, 2'd0, 1'b0, 1'b0, 16'h3F82, 5'h08, 4'd3},  // R3 tie to even up
    {32'h3F808001, 2'd0, 1'b0, 1'b0, 16'h3F81, 5'h08, 4'd3},  // R3 above half
    {32'h3F800001, 2'd1, 1'b0, 1'b0, 16'h3F81, 5'h08, 4'd3},  // R3 +inf dir
    {32'h3F800001, 2'd2, 1'b0, 1'b0, 16'h3F80, 5'h08, 4'd3},  // R3 -inf dir
    {32'h3F80FFFF, 2'd3, 1'b0, 1'b0, 16'h3F80, 5'h08, 4'd3},  // R3 toward zero
    {32'hBF800001, 2'd2, 1'b0, 1'b0, 16'hBF81, 5'h08, 4'd3},  // R3 neg -inf dir
    {32'hBF800001, 2'd1, 1'b0, 1'b0, 16'hBF80, 5'h08, 4'd3},  // R3 neg +inf dir
    {32'h7F7FFFFF, 2'd0, 1'b0, 1'b0, 16'h7F80, 5'h0A, 4'd4},  // R4 overflow
    {32'h7F7FFFFF, 2'd3, 1'b0, 1'b0, 16'h7F7F, 5'h08, 4'd4},  // R4 max finite
    {32'h7F7FFFFF, 2'd2, 1'b0, 1'b0, 16'h7F7F, 5'h08, 4'd4},  // R4
    {32'hFF7FFFFF, 2'd1, 1'b0, 1'b0, 16'hFF7F, 5'h08, 4'd4},  // R4
    {32'hFF7FFFFF, 2'd2, 1'b0, 1'b0, 16'hFF80, 5'h0A, 4'd4},  // R4
    {32'h7F800001, 2'd0, 1'b0, 1'b0, 16'h7FC0, 5'h01, 4'd5},  // R5 snan
    {32'hFFA10000, 2'd0, 1'b0, 1'b0, 16'hFFE1, 5'h01, 4'd5},  // R5 payload
    {32'hFFA10000, 2'd0, 1'b0, 1'b1, 16'h7FC0, 5'h01, 4'd5},  // R5 default nan
    {32'hFFC12345, 2'd0, 1'b0, 1'b0, 16'hFFC1, 5'h00, 4'd5},  // R5 qnan
    {32'hFFC12345, 2'd3, 1'b0, 1'b1, 16'h7FC0, 5'h00, 4'd5},  // R5
    {32'h80018000, 2'd0, 1'b1, 1'b0, 16'h8000, 5'h10, 4'd6},  // R6 flush
    {32'h00010000, 2'd0, 1'b0, 1'b0, 16'h0001, 5'h00, 4'd7},  // R7 exact subnormal
    {32'h00018000, 2'd0, 1'b0, 1'b0, 16'h0002, 5'h0C, 4'd7},  // R7 underflow
    {32'h007FFFFF, 2'd0, 1'b0, 1'b0, 16'h0080, 5'h0C, 4'd7},  // R7 to min normal
    {32'hFF800000, 2'd1, 1'b0, 1'b1, 16'hFF80, 5'h00, 4'd10}, // R10 inf
    {32'h80000000, 2'd0, 1'b1, 1'b0, 16'h8000, 5'h00, 4'd10}, // R10 zero under ftz
    {32'h3F800000, 2'd0, 1'b1, 1'b1, 16'h3F80, 5'h00, 4'd10}  // R10 controls idle
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [VL-1:0] src_vec = '0, dst_old = '0;
  logic [VL/8-1:0] pred = '0;
  logic [1:0]    rmode = '0;
  logic          ftz = 1'b0, dnan = 1'b0;
  logic [VL-1:0] dst_new;
  logic [4:0]    exc;
  int            checks = 0, fails = 0;

  always #4 clk = ~clk;

  bf16_narrow_top #(.VL(VL)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_vec(src_vec), .dst_old(dst_old), .pred(pred),
    .rmode(rmode), .ftz(ftz), .dnan(dnan), .dst_new(dst_new), .exc(exc));

  task automatic check(input string req, input logic [VL-1:0] ev, input logic [4:0] ef);
    checks++;
    if (dst_new !== ev || exc !== ef) begin
      fails++;
      $display("FAIL %s dst=%h exc=%h expected dst=%h exc=%h", req, dst_new, exc, ev, ef);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #2;
  endtask

  localparam logic [VL-1:0] OLD = 128'h0123456789ABCDEF_FEDCBA9876543210;

  initial begin
    #6;
    check("R9 reset", '0, 5'd0);
    @(negedge clk);
    rst_n = 1'b1;
    dst_old = OLD;
    for (int i = 0; i < N; i++) begin
      src_vec = {96'h7F800001_7F800001_7F800001, VEC[i][60:29]};
      rmode = VEC[i][28:27];
      ftz   = VEC[i][26];
      dnan  = VEC[i][25];
      pred  = 16'h0001;
      step();
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i),
            {OLD[127:32], VEC[i][24:9], OLD[15:0]}, VEC[i][8:4]);
    end
    // R1 R2 R8: lanes 0 and 2 active, non-lane predicate bits set
    src_vec = {32'h7F7FFFFF, 32'h3F808001, 32'h7F800001, 32'h3F800000};
    dst_old = 128'hAAAA5555_CCCC3333_F0F00F0F_12344321;
    rmode = 2'd0; ftz = 1'b0; dnan = 1'b0;
    pred = 16'hEFEF;
    step();
    check("R2 R8 mixed predicate",
          128'hAAAA5555_3F813333_F0F00F0F_3F804321, 5'h08);
    pred = 16'h1111;
    step();
    check("R1 R8 all lanes",
          128'h7F805555_3F813333_7FC00F0F_3F804321, 5'h0B);
    pred = 16'hEEEE;
    step();
    check("R2 R8 no active lane", 128'hAAAA5555_CCCC3333_F0F00F0F_12344321, 5'h00);
    // R9 latency: change inputs, output holds until the edge
    pred = 16'h0001;
    #1;
    check("R9 holds before edge", 128'hAAAA5555_CCCC3333_F0F00F0F_12344321, 5'h00);
    step();
    check("R9 updates after edge", 128'hAAAA5555_CCCC3333_F0F00F0F_3F804321, 5'h00);
    rst_n = 1'b0;
    #1;
    check("R9 async reset", '0, 5'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule